// File: doc/BRIEF.md
# Drive Level Adjust Merger

During link training a display sink reports, for each lane, the voltage swing and pre-emphasis it would like the source to use. This block turns those per-lane wishes into one drive setting shared by every lane. A one-cycle start pulse captures the packed request bytes and the active lane count. The block then walks the active lanes, one per clock, and keeps the largest swing and the largest pre-emphasis it sees.

After the last lane it limits both values. Swing stops at its top level. The pre-emphasis ceiling depends on the swing that was chosen. Each limit that is reached raises its own flag. The result is presented as four identical lane training bytes, together with a single-cycle done pulse. The training bytes then hold their value until the next result is produced.

Top module: `drive_level_merger`

## Requirements
- R1: While reset is asserted, and after it is released with no start, all four training bytes read 0x00 and done is low.
- R2: Lane n's 4-bit request field sits in request byte n>>1 (byte 0 = adj_req_i[7:0]). The upper nibble belongs to odd lanes and the lower nibble to even lanes. Inside a field, bits [1:0] hold the swing request and bits [3:2] hold the pre-emphasis request.
- R3: The merged swing is the largest swing request over the active lanes, and the merged pre-emphasis is the largest pre-emphasis request over the active lanes. Fields of inactive lanes have no effect.
- R4: A merged swing of 3 is output as 3, with the max-swing flag set. Any lower swing leaves the flag clear.
- R5: The pre-emphasis ceiling is 2 for swing 0 or 1, 1 for swing 2, and 0 for swing 3. A merged pre-emphasis at or above the ceiling is output as the ceiling, with the max-pre-emphasis flag set. Otherwise the value passes through unchanged and the flag stays clear.
- R6: Each training byte carries swing in bits [1:0], the max-swing flag in bit 2, pre-emphasis in bits [4:3] and the max-pre-emphasis flag in bit 5, with bits [7:6] zero. All four bytes (byte k = train_set_o[8k+7:8k]) are equal, whatever the lane count.
- R7: A lane count of 1 or 2 activates that many lanes, starting from lane 0. Every other value activates all four lanes.
- R8: With N active lanes, done rises exactly N+1 clock edges after the edge that accepts start, and it stays high for one cycle. The new training bytes appear in that same cycle.
- R9: A start that arrives while a merge is in progress is ignored. The request bytes and lane count are captured when start is accepted, and later changes to them do not affect that result.
- R10: The training bytes change only in a cycle where done is high. Between results they hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a merge; accepted only when idle |
| lane_count_i | input | 3 | Active lanes: 1, 2, otherwise all four |
| adj_req_i | input | 16 | Packed per-lane request bytes |
| train_set_o | output | 32 | Four identical lane training bytes |
| done_o | output | 1 | One-cycle pulse when a new result is presented |

## Verification
The assertions rely on the block's inputs being sampled only at clock edges and on reset being held for at least one edge. They do not constrain start, lane count or request values, so any pattern is legal. The stimulus changes inputs only on falling edges. It drives every lane count code from 0 to 7, holds start high through and across busy periods, and alters the request bytes in the middle of a scan. This keeps the timing model in the bench exact for every accepted or ignored start.

// File: rtl/dla_pkg.sv
package dla_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_FIN  = 2'd2
    } dla_state_e;
endpackage

// File: rtl/dla_lane_pick.sv
module dla_lane_pick #(
    parameter int LANES = 4,
    parameter int LVL_W = 2,
    parameter int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES*2*LVL_W-1:0] req_i,
    input  logic [IDX_W-1:0]         idx_i,
    output logic [LVL_W-1:0]         swing_o,
    output logic [LVL_W-1:0]         pre_o
);
    localparam int FIELD_W = 2 * LVL_W;

    logic [FIELD_W-1:0] fields [LANES];
    logic [FIELD_W-1:0] sel;

    for (genvar g = 0; g < LANES; g++) begin : g_field
        assign fields[g] = req_i[g*FIELD_W +: FIELD_W];
    end

    assign sel     = fields[idx_i];
    assign swing_o = sel[LVL_W-1:0];
    assign pre_o   = sel[FIELD_W-1:LVL_W];
endmodule

// File: rtl/dla_level_clamp.sv
module dla_level_clamp #(
    parameter int LVL_W  = 2,
    parameter int BYTE_W = 8
) (
    input  logic [LVL_W-1:0]  swing_i,
    input  logic [LVL_W-1:0]  pre_i,
    output logic [BYTE_W-1:0] byte_o
);
    localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};
    localparam logic [LVL_W-1:0] LVL_ONE = LVL_W'(1);
    localparam int PAD_W = BYTE_W - 2*LVL_W - 2;

    logic [LVL_W-1:0] swing_c, pre_c, ceil_c;
    logic             swing_top, pre_top;

    always_comb begin
        swing_top = (swing_i >= LVL_MAX);
        swing_c   = swing_top ? LVL_MAX : swing_i;
        ceil_c    = (swing_c <= LVL_ONE) ? (LVL_MAX - LVL_ONE) : (LVL_MAX - swing_c);
        pre_top   = (pre_i >= ceil_c);
        pre_c     = pre_top ? ceil_c : pre_i;
        byte_o    = {{PAD_W{1'b0}}, pre_top, pre_c, swing_top, swing_c};
    end
endmodule

// File: rtl/drive_level_merger.sv
module drive_level_merger #(
    parameter int LANES  = 4,
    parameter int LVL_W  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [$clog2(LANES):0]      lane_count_i,
    input  logic [LANES*2*LVL_W-1:0]    adj_req_i,
    output logic [LANES*BYTE_W-1:0]     train_set_o,
    output logic                        done_o
);
    import dla_pkg::*;

    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int CNT_W = $clog2(LANES) + 1;
    localparam int REQ_W = LANES * 2 * LVL_W;

    typedef struct packed {
        dla_state_e        state;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
        logic [REQ_W-1:0]  req;
        logic [LVL_W-1:0]  vmax;
        logic [LVL_W-1:0]  pmax;
        logic [BYTE_W-1:0] train;
        logic              done;
    } regs_t;

    regs_t q, d;

    logic [LVL_W-1:0]  lane_swing, lane_pre;
    logic [BYTE_W-1:0] merged_byte;

    function automatic logic [IDX_W-1:0] last_lane(input logic [CNT_W-1:0] cnt);
        if (cnt == CNT_W'(1)) return IDX_W'(0);
        if (cnt == CNT_W'(2)) return IDX_W'(1);
        return IDX_W'(LANES - 1);
    endfunction

    dla_lane_pick #(.LANES(LANES), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_pick (
        .req_i   (q.req),
        .idx_i   (q.idx),
        .swing_o (lane_swing),
        .pre_o   (lane_pre)
    );

    dla_level_clamp #(.LVL_W(LVL_W), .BYTE_W(BYTE_W)) u_clamp (
        .swing_i (q.vmax),
        .pre_i   (q.pmax),
        .byte_o  (merged_byte)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.state = ST_SCAN;
                    d.idx   = '0;
                    d.last  = last_lane(lane_count_i);
                    d.req   = adj_req_i;
                    d.vmax  = '0;
                    d.pmax  = '0;
                end
            end
            ST_SCAN: begin
                if (lane_swing > q.vmax) d.vmax = lane_swing;
                if (lane_pre > q.pmax)   d.pmax = lane_pre;
                if (q.idx == q.last) d.state = ST_FIN;
                else                 d.idx   = q.idx + IDX_W'(1);
            end
            ST_FIN: begin
                d.train = merged_byte;
                d.done  = 1'b1;
                d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_out
        assign train_set_o[g*BYTE_W +: BYTE_W] = q.train;
    end
    assign done_o = q.done;

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_scan_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SCAN) |-> (q.idx <= q.last));

    assert_capture_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SCAN) |=> $stable(q.req));

    assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.train) |-> done_o);

    assert_pre_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (train_set_o[1:0] == 2'd3) |-> (train_set_o[4:3] == 2'd0));

    assert_pre_ceiling_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (train_set_o[1:0] == 2'd2) |-> (train_set_o[4:3] <= 2'd1));

    assert_swing_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        train_set_o[2] |-> (train_set_o[1:0] == 2'd3));
endmodule

// File: tb/drive_level_merger_test.sv
`timescale 1ns/1ps
module drive_level_merger_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  lane_count_i = 3'd1;
    logic [15:0] adj_req_i = 16'h0;
    logic [31:0] train_set_o;
    logic        done_o;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit checking = 1'b0;
    string tag = "R1";

    int          cnt = 0;
    logic [15:0] cap_req = 16'h0;
    int          cap_n = 4;
    logic        exp_done = 1'b0;
    logic [31:0] exp_train = 32'h0;

    always #2.5 clk = ~clk;

    drive_level_merger uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .lane_count_i (lane_count_i),
        .adj_req_i    (adj_req_i),
        .train_set_o  (train_set_o),
        .done_o       (done_o)
    );

    function automatic int lanes_of(input logic [2:0] c);
        if (c == 3'd1) return 1;
        if (c == 3'd2) return 2;
        return 4;
    endfunction

    function automatic logic [31:0] merge(input logic [15:0] r, input int n);
        int v = 0, p = 0, ceil, sf, pf, b;
        for (int l = 0; l < n; l++) begin
            int f = (r >> (l*4)) & 15;
            if ((f & 3) > v) v = f & 3;
            if ((f >> 2) > p) p = f >> 2;
        end
        sf = (v >= 3);
        if (sf != 0) v = 3;
        ceil = (v <= 1) ? 2 : (v == 2 ? 1 : 0);
        pf = (p >= ceil);
        if (pf != 0) p = ceil;
        b = v | (sf << 2) | (p << 3) | (pf << 5);
        return {4{8'(b)}};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            cnt = 0; exp_done = 1'b0; exp_train = 32'h0;
        end else begin
            exp_done = 1'b0;
            if (cnt == 0) begin
                if (start_i) begin
                    cap_n = lanes_of(lane_count_i);
                    cap_req = adj_req_i;
                    cnt = cap_n + 1;
                end
            end else begin
                cnt = cnt - 1;
                if (cnt == 0) begin
                    exp_done = 1'b1;
                    exp_train = merge(cap_req, cap_n);
                end
            end
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (checking) begin
            compared++;
            if (done_o !== exp_done || train_set_o !== exp_train) begin
                mismatched++;
                $display("FAIL %s: done=%0b train=%08h expected done=%0b train=%08h",
                         tag, done_o, train_set_o, exp_done, exp_train);
            end
        end
        if (cycles > 150000) begin
            mismatched++;
            $display("FAIL watchdog: cycles=%0d expected completion", cycles);
            finish_run();
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    task automatic go(input logic [2:0] c, input logic [15:0] r, input int wait_cycles);
        @(negedge clk);
        start_i = 1'b1; lane_count_i = c; adj_req_i = r;
        @(negedge clk);
        start_i = 1'b0;
        repeat (wait_cycles) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checking = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1"; repeat (4) @(negedge clk);
        tag = "R2"; go(3'd2, 16'h0010, 6); go(3'd4, 16'h2000, 6); go(3'd4, 16'h0400, 6);
        tag = "R3"; go(3'd1, 16'hFFF0, 6); go(3'd2, 16'hFF41, 6);
        tag = "R4"; go(3'd1, 16'h0003, 6); go(3'd4, 16'h0200, 6);
        tag = "R5"; go(3'd1, 16'h000C, 6); go(3'd1, 16'h0006, 6); go(3'd1, 16'h0005, 6);
        tag = "R6"; go(3'd1, 16'h0009, 6);
        tag = "R7"; go(3'd3, 16'h1000, 6); go(3'd0, 16'h0300, 6); go(3'd7, 16'h4000, 6);
        tag = "R8"; go(3'd4, 16'h1111, 0); go(3'd1, 16'h0002, 0); go(3'd2, 16'h0020, 3);
        tag = "R9";
        @(negedge clk); start_i = 1'b1; lane_count_i = 3'd4; adj_req_i = 16'h0001;
        @(negedge clk); lane_count_i = 3'd1; adj_req_i = 16'hFFFF;
        @(negedge clk); adj_req_i = 16'h3333;
        @(negedge clk); start_i = 1'b0;
        repeat (8) @(negedge clk);
        tag = "R10";
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); adj_req_i = 16'($urandom); lane_count_i = 3'($urandom);
        end
        tag = "R8";
        for (int i = 0; i < 400; i++) begin
            int hold = 1 + ($urandom % 3);
            @(negedge clk);
            start_i = 1'b1; lane_count_i = 3'($urandom); adj_req_i = 16'($urandom);
            repeat (hold) @(negedge clk);
            start_i = 1'b0;
            adj_req_i = 16'($urandom);
            repeat ($urandom % 6) @(negedge clk);
        end
        repeat (8) @(negedge clk);
        finish_run();
    end
endmodule